// File: doc/BRIEF.md
# Performance monitor counter box

This block is a box of four general-purpose event counters that software programs through a small register window. Each counter has its own control register. The control register turns counting on and picks one of eight single-bit event strobes. When the counter is enabled, the box is not frozen and the chosen strobe is high on a clock edge, the counter adds one. Each counter is 48 bits wide and is seen on the bus as a low word and a high word.

A box-wide control register carries three command bits. One freezes every counter. One clears every count to zero. One clears every counter control register. A box-wide status register holds a sticky overflow flag per counter, and software clears a flag by writing 1 to its bit. The bus is synchronous. A write takes effect at the clock edge where `wr_i` is high, and read data is a combinational function of `addr_i` and the current state.

Top module: `perfmon_box`

## Requirements
- R1: After reset every count, every control register, the freeze flag and every overflow flag are 0, so every mapped address reads 0.
- R2: Counter i adds exactly 1 on an edge where its control bit 22 is 1, the box is not frozen and `events_i[sel]` is 1, where sel is control bits 7:0. A sel value of 8 or more never counts.
- R3: A box control write (offset F4) with bit 8 set freezes the box from the next edge onward. While the box is frozen no count changes except by a software write. A later box control write with bit 8 clear unfreezes it.
- R4: A box control write with bit 1 set clears all four counts to 0 at that edge, and no count advances on that edge.
- R5: A box control write with bit 0 set clears all four counter control registers to 0.
- R6: Box control always reads 0. A counter control register (offsets D8, DC, E0, E4 for counters 0 to 3) stores and returns only bit 22 and bits 7:0, and its other bits read 0.
- R7: Counter i sits at offset A0+8i (bits 31:0) and at A4+8i (bits 47:32 in read bits 15:0, with bits 31:16 reading 0). A write to either word loads it, and on that edge the write wins over counting.
- R8: When counter i wraps from all ones to zero by counting, status bit i at offset F8 becomes 1 and stays 1. Status bits 31:4 read 0.
- R9: A status write clears every bit where the write data is 1 and leaves every bit where it is 0. A wrap on the same edge as a clear of that bit leaves the bit set.
- R10: Unmapped offsets read 0, and a write to them changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe for the register at `addr_i` |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| events_i | input | 8 | Event strobes that the counters can select |
| rdata_o | output | 32 | Read data for `addr_i` |

## Verification
The bench preloads a counter to all ones and lets it wrap. This checks that the overflow flag rises on the same edge as the zero count, and not one edge late. It then lines up a wrap with a write-1-to-clear of the same bit. A design that gives the clear priority would lose that overflow without any sign of it. Freeze is tested both on the edge of the freeze write and on the edges after it. A design that uses the write data directly instead of the stored flag would stop counting one edge early. The bench also checks out-of-range event selects, reads of the high word, masking of the control fields, and a long stretch of mixed traffic against the model.

// File: rtl/pmon_pkg.sv
package pmon_pkg;
  localparam int PM_DATA_W  = 32;
  localparam int PM_NUM_CTR = 4;
  localparam int PM_CTR_W   = 48;
  localparam int PM_EVT_N   = 8;
  localparam int PM_SEL_W   = 8;

  // register offsets
  localparam logic [7:0] CTR_BASE   = 8'hA0;
  localparam logic [7:0] CTL_BASE   = 8'hD8;
  localparam logic [7:0] BOX_CTL_A  = 8'hF4;
  localparam logic [7:0] BOX_STAT_A = 8'hF8;

  // bit positions
  localparam int FRZ_BIT     = 8;
  localparam int RST_CTR_BIT = 1;
  localparam int RST_CTL_BIT = 0;
  localparam int EN_BIT      = 22;

  typedef struct packed {
    logic                en;
    logic [PM_SEL_W-1:0] sel;
  } ctl_t;
endpackage

// File: rtl/pmon_decode.sv
module pmon_decode
  import pmon_pkg::*;
#(
  parameter int NUM_CTR = PM_NUM_CTR
) (
  input  logic               wr_i,
  input  logic [7:0]         addr_i,
  output logic [NUM_CTR-1:0] ld_lo_o,
  output logic [NUM_CTR-1:0] ld_hi_o,
  output logic [NUM_CTR-1:0] ctl_we_o,
  output logic               box_we_o,
  output logic               stat_we_o
);
  for (genvar i = 0; i < NUM_CTR; i++) begin : g_dec
    localparam logic [7:0] LO_A  = 8'(int'(CTR_BASE) + 8 * i);
    localparam logic [7:0] HI_A  = 8'(int'(CTR_BASE) + 8 * i + 4);
    localparam logic [7:0] CTL_A = 8'(int'(CTL_BASE) + 4 * i);
    assign ld_lo_o[i]  = wr_i && (addr_i == LO_A);
    assign ld_hi_o[i]  = wr_i && (addr_i == HI_A);
    assign ctl_we_o[i] = wr_i && (addr_i == CTL_A);
  end

  assign box_we_o  = wr_i && (addr_i == BOX_CTL_A);
  assign stat_we_o = wr_i && (addr_i == BOX_STAT_A);
endmodule

// File: rtl/pmon_ctl_reg.sv
module pmon_ctl_reg
  import pmon_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                we_i,
  input  logic                en_i,
  input  logic [PM_SEL_W-1:0] sel_i,
  output ctl_t                ctl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_o <= '0;
    end else if (clr_i) begin
      ctl_o <= '0;
    end else if (we_i) begin
      ctl_o.en  <= en_i;
      ctl_o.sel <= sel_i;
    end
  end
endmodule

// File: rtl/pmon_counter.sv
module pmon_counter
  import pmon_pkg::*;
#(
  parameter int CTR_W = PM_CTR_W,
  parameter int EVT_N = PM_EVT_N
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  ctl_t                 ctl_i,
  input  logic                 frz_i,
  input  logic [EVT_N-1:0]     events_i,
  input  logic                 clr_i,
  input  logic                 ld_lo_i,
  input  logic                 ld_hi_i,
  input  logic [PM_DATA_W-1:0] wdata_i,
  output logic [CTR_W-1:0]     cnt_o,
  output logic                 wrap_o
);
  localparam int SIDX_W = (EVT_N > 1) ? $clog2(EVT_N) : 1;
  localparam logic [PM_SEL_W-1:0] SEL_LIM = PM_SEL_W'(EVT_N);
  localparam int HI_W = CTR_W - PM_DATA_W;

  logic hit, inc;

  always_comb begin
    hit = 1'b0;
    if (ctl_i.sel < SEL_LIM) hit = events_i[ctl_i.sel[SIDX_W-1:0]];
  end

  // software access on this edge suppresses counting
  assign inc    = ctl_i.en & ~frz_i & hit & ~clr_i & ~ld_lo_i & ~ld_hi_i;
  assign wrap_o = inc & (&cnt_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
    end else if (clr_i) begin
      cnt_o <= '0;
    end else if (ld_lo_i) begin
      cnt_o[PM_DATA_W-1:0] <= wdata_i;
    end else if (ld_hi_i) begin
      cnt_o[CTR_W-1:PM_DATA_W] <= wdata_i[HI_W-1:0];
    end else if (inc) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/pmon_box_state.sv
module pmon_box_state
  import pmon_pkg::*;
#(
  parameter int NUM_CTR = PM_NUM_CTR
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               box_we_i,
  input  logic               frz_bit_i,
  input  logic               rst_ctr_bit_i,
  input  logic               rst_ctl_bit_i,
  input  logic               stat_we_i,
  input  logic [NUM_CTR-1:0] stat_mask_i,
  input  logic [NUM_CTR-1:0] wrap_i,
  output logic               frz_o,
  output logic               clr_ctr_o,
  output logic               clr_ctl_o,
  output logic [NUM_CTR-1:0] ov_o
);
  assign clr_ctr_o = box_we_i & rst_ctr_bit_i;
  assign clr_ctl_o = box_we_i & rst_ctl_bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       frz_o <= 1'b0;
    else if (box_we_i) frz_o <= frz_bit_i;
  end

  logic [NUM_CTR-1:0] clr_mask;
  assign clr_mask = stat_we_i ? stat_mask_i : '0;

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ov_o <= '0;
    else         ov_o <= (ov_o & ~clr_mask) | wrap_i;
  end
endmodule

// File: rtl/perfmon_box.sv
module perfmon_box
  import pmon_pkg::*;
#(
  parameter int NUM_CTR = PM_NUM_CTR,
  parameter int CTR_W   = PM_CTR_W,
  parameter int EVT_N   = PM_EVT_N
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [7:0]           addr_i,
  input  logic [PM_DATA_W-1:0] wdata_i,
  input  logic [EVT_N-1:0]     events_i,
  output logic [PM_DATA_W-1:0] rdata_o
);
  localparam int HI_W = CTR_W - PM_DATA_W;

  logic [NUM_CTR-1:0] ld_lo, ld_hi, ctl_we, wrap, ov_q;
  logic               box_we, stat_we, frz_q, clr_ctr, clr_ctl;
  ctl_t [NUM_CTR-1:0] ctl_q;
  logic [NUM_CTR-1:0][CTR_W-1:0] cnt_q;

  pmon_decode #(.NUM_CTR(NUM_CTR)) u_dec (
    .wr_i     (wr_i),
    .addr_i   (addr_i),
    .ld_lo_o  (ld_lo),
    .ld_hi_o  (ld_hi),
    .ctl_we_o (ctl_we),
    .box_we_o (box_we),
    .stat_we_o(stat_we)
  );

  pmon_box_state #(.NUM_CTR(NUM_CTR)) u_box (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .box_we_i     (box_we),
    .frz_bit_i    (wdata_i[FRZ_BIT]),
    .rst_ctr_bit_i(wdata_i[RST_CTR_BIT]),
    .rst_ctl_bit_i(wdata_i[RST_CTL_BIT]),
    .stat_we_i    (stat_we),
    .stat_mask_i  (wdata_i[NUM_CTR-1:0]),
    .wrap_i       (wrap),
    .frz_o        (frz_q),
    .clr_ctr_o    (clr_ctr),
    .clr_ctl_o    (clr_ctl),
    .ov_o         (ov_q)
  );

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    pmon_ctl_reg u_ctl (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (clr_ctl),
      .we_i  (ctl_we[i]),
      .en_i  (wdata_i[EN_BIT]),
      .sel_i (wdata_i[PM_SEL_W-1:0]),
      .ctl_o (ctl_q[i])
    );

    pmon_counter #(.CTR_W(CTR_W), .EVT_N(EVT_N)) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .ctl_i   (ctl_q[i]),
      .frz_i   (frz_q),
      .events_i(events_i),
      .clr_i   (clr_ctr),
      .ld_lo_i (ld_lo[i]),
      .ld_hi_i (ld_hi[i]),
      .wdata_i (wdata_i),
      .cnt_o   (cnt_q[i]),
      .wrap_o  (wrap[i])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_CTR; i++) begin
      if (addr_i == 8'(int'(CTR_BASE) + 8 * i))
        rdata_o = cnt_q[i][PM_DATA_W-1:0];
      if (addr_i == 8'(int'(CTR_BASE) + 8 * i + 4))
        rdata_o[HI_W-1:0] = cnt_q[i][CTR_W-1:PM_DATA_W];
      if (addr_i == 8'(int'(CTL_BASE) + 4 * i)) begin
        rdata_o[EN_BIT]       = ctl_q[i].en;
        rdata_o[PM_SEL_W-1:0] = ctl_q[i].sel;
      end
    end
    if (addr_i == BOX_STAT_A) rdata_o[NUM_CTR-1:0] = ov_q;
  end
endmodule

// File: rtl/perfmon_box_chk.sv
module perfmon_box_chk
  import pmon_pkg::*;
#(
  parameter int NUM_CTR = PM_NUM_CTR,
  parameter int CTR_W   = PM_CTR_W
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          wr_i,
  input logic [7:0]                    addr_i,
  input logic [PM_DATA_W-1:0]          wdata_i,
  input logic [PM_DATA_W-1:0]          rdata_o,
  input logic                          frz_q,
  input logic [NUM_CTR-1:0]            ov_q,
  input ctl_t [NUM_CTR-1:0]            ctl_q,
  input logic [NUM_CTR-1:0][CTR_W-1:0] cnt_q
);
  localparam logic [CTR_W-1:0] ONE = CTR_W'(1);

  assert_frozen_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frz_q && !wr_i |=> $stable(cnt_q));

  assert_rst_ctrs_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == BOX_CTL_A && wdata_i[RST_CTR_BIT] |=> cnt_q == '0);

  assert_rst_ctl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == BOX_CTL_A && wdata_i[RST_CTL_BIT] |=> ctl_q == '0);

  assert_box_ctl_reads_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == BOX_CTL_A |-> rdata_o == '0);

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_chk
    assert_step_by_one_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_i |=> (cnt_q[i] == $past(cnt_q[i])) || (cnt_q[i] == $past(cnt_q[i]) + ONE));

    assert_ov_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ov_q[i] && !wr_i |=> ov_q[i]);

    assert_w0_keeps_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ov_q[i] && wr_i && addr_i == BOX_STAT_A && !wdata_i[i] |=> ov_q[i]);
  end
endmodule

bind perfmon_box perfmon_box_chk #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .wr_i   (wr_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .rdata_o(rdata_o),
  .frz_q  (frz_q),
  .ov_q   (ov_q),
  .ctl_q  (ctl_q),
  .cnt_q  (cnt_q)
);

// File: tb/perfmon_box_test.sv
`timescale 1ns/1ps
module perfmon_box_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [7:0]  events_i = '0;
  logic [31:0] rdata_o;

  int n_cmp = 0;
  int n_bad = 0;

  // reference state
  logic [47:0] cnt_m [4];
  logic        en_m  [4];
  logic [7:0]  sel_m [4];
  logic        frz_m;
  logic [3:0]  ov_m;

  always #2 clk = ~clk;

  perfmon_box uut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .wr_i    (wr_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .events_i(events_i),
    .rdata_o (rdata_o)
  );

  function automatic logic [31:0] model_read(input logic [7:0] a);
    logic [31:0] r = '0;
    for (int i = 0; i < 4; i++) begin
      if (a == 8'(8'hA0 + 8 * i))     r = cnt_m[i][31:0];
      if (a == 8'(8'hA4 + 8 * i))     r = {16'h0, cnt_m[i][47:32]};
      if (a == 8'(8'hD8 + 4 * i))     r = {9'h0, en_m[i], 14'h0, sel_m[i]};
    end
    if (a == 8'hF8) r = {28'h0, ov_m};
    return r;
  endfunction

  task automatic model_update(input logic w, input logic [7:0] a,
                              input logic [31:0] d, input logic [7:0] ev);
    logic [3:0] wrap = '0;
    logic [47:0] nc [4];
    for (int i = 0; i < 4; i++) begin
      bit hit = (sel_m[i] < 8) && ev[sel_m[i][2:0]];
      bit lo  = w && a == 8'(8'hA0 + 8 * i);
      bit hi  = w && a == 8'(8'hA4 + 8 * i);
      bit clr = w && a == 8'hF4 && d[1];
      bit inc = en_m[i] && !frz_m && hit;
      nc[i] = cnt_m[i];
      if (clr)      nc[i] = '0;
      else if (lo)  nc[i][31:0] = d;
      else if (hi)  nc[i][47:32] = d[15:0];
      else if (inc) begin
        if (cnt_m[i] == 48'hFFFF_FFFF_FFFF) wrap[i] = 1'b1;
        nc[i] = cnt_m[i] + 48'd1;
      end
    end
    for (int i = 0; i < 4; i++) begin
      cnt_m[i] = nc[i];
      if (w && a == 8'hF4 && d[0]) begin
        en_m[i] = 1'b0; sel_m[i] = '0;
      end else if (w && a == 8'(8'hD8 + 4 * i)) begin
        en_m[i] = d[22]; sel_m[i] = d[7:0];
      end
    end
    if (w && a == 8'hF4) frz_m = d[8];
    if (w && a == 8'hF8) ov_m = ov_m & ~d[3:0];
    ov_m = ov_m | wrap;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [7:0] a, input logic [31:0] d,
                      input logic [7:0] ev, input string tag);
    @(negedge clk);
    wr_i = w; addr_i = a; wdata_i = d; events_i = ev;
    #1 check(tag, rdata_o, model_read(a));
    @(posedge clk);
    model_update(w, a, d, ev);
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    step(1'b0, a, 32'h0, 8'h00, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rnd = 32'h1234_5678;
    logic [7:0] amap [15] = '{8'hA0, 8'hA4, 8'hA8, 8'hAC, 8'hB0, 8'hB4, 8'hB8, 8'hBC,
                              8'hD8, 8'hDC, 8'hE0, 8'hE4, 8'hF4, 8'hF8, 8'h10};
    for (int i = 0; i < 4; i++) begin
      cnt_m[i] = '0; en_m[i] = 1'b0; sel_m[i] = '0;
    end
    frz_m = 1'b0; ov_m = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int k = 0; k < 15; k++) rd(amap[k], "R1");

    // R2 enable + select, including out-of-range select on counter 2
    step(1, 8'hD8, 32'h0040_0000, 8'h00, "R2");
    step(1, 8'hDC, 32'h0040_0003, 8'h00, "R2");
    step(1, 8'hE0, 32'h0040_0009, 8'h00, "R2");
    step(1, 8'hE4, 32'h0040_0007, 8'h00, "R2");
    for (int k = 0; k < 12; k++) step(0, amap[k % 8], 0, 8'(k * 37 + 1), "R2");
    step(0, 8'hB0, 0, 8'hFF, "R2");
    rd(8'hB0, "R2");
    rd(8'hA0, "R2");
    rd(8'hA8, "R2");

    // R3 freeze, events active on the freeze edge itself
    step(1, 8'hF4, 32'h0000_0100, 8'hFF, "R3");
    for (int k = 0; k < 5; k++) step(0, amap[k], 0, 8'hFF, "R3");
    rd(8'hA0, "R3");
    rd(8'hB8, "R3");
    step(1, 8'hF4, 32'h0000_0000, 8'hFF, "R3");
    step(0, 8'hA0, 0, 8'hFF, "R3");
    rd(8'hA0, "R3");

    // R7 word loads, high word masking, load wins over counting
    step(1, 8'hA4, 32'hFFFF_ABCD, 8'hFF, "R7");
    rd(8'hA4, "R7");
    step(1, 8'hA0, 32'h1111_2222, 8'hFF, "R7");
    rd(8'hA0, "R7");

    // R8 overflow on counter 3
    step(1, 8'hBC, 32'h0000_FFFF, 8'h00, "R7");
    step(1, 8'hB8, 32'hFFFF_FFFE, 8'h00, "R7");
    rd(8'hBC, "R7");
    step(0, 8'hF8, 0, 8'h80, "R8");
    step(0, 8'hF8, 0, 8'h80, "R8");
    rd(8'hF8, "R8");
    rd(8'hB8, "R8");
    for (int k = 0; k < 4; k++) rd(8'hF8, "R8");

    // R9 write-0 keeps, write-1 clears, set beats clear
    step(1, 8'hF8, 32'hFFFF_FFF0, 8'h00, "R9");
    rd(8'hF8, "R9");
    step(1, 8'hF8, 32'h0000_0008, 8'h00, "R9");
    rd(8'hF8, "R9");
    step(1, 8'hBC, 32'h0000_FFFF, 8'h00, "R9");
    step(1, 8'hB8, 32'hFFFF_FFFF, 8'h00, "R9");
    step(1, 8'hF8, 32'h0000_0008, 8'h80, "R9");
    rd(8'hF8, "R9");

    // R6 field masking and box control readback
    step(1, 8'hDC, 32'hFFFF_FFFF, 8'hFF, "R6");
    rd(8'hDC, "R6");
    step(0, 8'hA8, 0, 8'hFF, "R6");
    rd(8'hA8, "R6");
    step(1, 8'hF4, 32'hFFFF_FEFC, 8'h00, "R6");
    rd(8'hF4, "R6");

    // R10 unmapped
    step(1, 8'h10, 32'hFFFF_FFFF, 8'hFF, "R10");
    rd(8'h10, "R10");
    rd(8'h00, "R10");
    rd(8'hF0, "R10");

    // R4 clear counters, events high on that edge
    step(1, 8'hF4, 32'h0000_0002, 8'hFF, "R4");
    for (int k = 0; k < 8; k += 2) rd(amap[k], "R4");

    // R5 clear controls
    step(1, 8'hF4, 32'h0000_0001, 8'hFF, "R5");
    for (int k = 8; k < 12; k++) rd(amap[k], "R5");

    // mixed traffic
    for (int k = 0; k < 4000; k++) begin
      logic w;
      logic [7:0] a;
      rnd = rnd ^ (rnd << 13); rnd = rnd ^ (rnd >> 17); rnd = rnd ^ (rnd << 5);
      w = (rnd[3:0] == 4'h0);
      a = amap[int'(rnd[31:24]) % 15];
      if (w && a == 8'hF4) step(w, a, rnd & 32'h0000_0100, rnd[15:8], "R3");
      else step(w, a, w && a[7:4] == 4'hD ? (rnd | 32'h0040_0000) & 32'hFFFF_FF07 : rnd,
                rnd[15:8], "R2");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule